// File: doc/BRIEF.md
# Sensor-Gate Line Second Vertical Sequence

This block drives four vertical CCD clock outputs. On every line, each output follows the normal vertical sequence. The normal sequence comes in from an upstream generator and repeats what the previous line produced.

On a line where the sensor-gate pulses are active, and only when the mode enable is set, each output can switch to a second waveform partway through the line. Three settings, fixed per output, control that switch:
- a start pixel;
- a pointer into a shared pool of twelve sequence waveforms;
- a polarity-invert bit.

Once the pixel counter reaches an output's start pixel, that output carries the selected pool waveform until the next line-start strobe.

All programmed values are captured at the line-start strobe. Software can therefore rewrite them at any time without disturbing the line in progress.

Top module: `sgl_vseq`

## Requirements
- R1: While reset is asserted, and for the two synchronizer cycles after it is released, all four outputs are 0.
- R2: On a line whose strobe cycle saw the sensor-gate flag low or the mode enable low, each output equals the normal sequence bit, registered one cycle (output in cycle t+1 equals `norm_v` in cycle t).
- R3: On an enabled sensor-gate line, an output equals the registered normal sequence bit until the pixel counter first equals that output's start position. The pixel counter is compared from the cycle after the strobe onward.
- R4: From the cycle in which `pix_cnt` equals an output's start position until the next strobe, the output equals, one cycle later, bit `ptr` of `seq_pool`. Here `ptr` is that output's pointer field (pointer k selects `seq_pool[k]`, k = 0..11). A start position the counter never reaches leaves the output on the normal sequence.
- R5: When an output's invert bit is 1, the second-sequence level it drives is the complement of the selected pool bit.
- R6: A pointer value of 12 to 15 makes the output drive 0 during the second sequence, whatever the invert bit.
- R7: The mode enable, start positions, pointers and invert bits are sampled only in the strobe cycle. Changes made during a line do not affect that line.
- R8: The four outputs are independent. The fields of output i sit at `start_pos[12*i +: 12]`, `seq_ptr[4*i +: 4]` and `seq_inv[i]`, and output i is `v_out[i]`.
- R9: In the cycle after a strobe, every output equals the normal sequence bit of the strobe cycle. This ends any second sequence of the line before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hd | input | 1 | Line-start strobe, one cycle |
| pix_cnt | input | 12 | Pixel position within the line, valid from the cycle after `hd` |
| sg_line | input | 1 | High in the strobe cycle when the new line is a sensor-gate line |
| norm_v | input | 4 | Normal vertical sequence levels for the four outputs |
| seq_pool | input | 12 | Current levels of the twelve pool waveforms |
| mode_en | input | 1 | Enables the second sequence on sensor-gate lines |
| start_pos | input | 48 | Four 12-bit second-sequence start pixels |
| seq_ptr | input | 16 | Four 4-bit pool pointers |
| seq_inv | input | 4 | Per-output invert bits |
| v_out | output | 4 | Vertical clock outputs |

## Verification
The assertions check the following on every cycle:
- the hand-back to the normal sequence after each strobe;
- pass-through of the normal sequence on lines that are not armed;
- the zero level for illegal pointers;
- that a second sequence, once started, stays latched;
- that the captured settings do not move between strobes.

Only the bench's scenarios can show the following, because each needs a reference model of pixel positions and settings:
- that each output switches in exactly the cycle its own start pixel is reached;
- that the correct pool entry and polarity are picked;
- that settings rewritten in the middle of a line leave that line untouched.

// File: rtl/sgl_pkg.sv
package sgl_pkg;
  parameter int NUM_V   = 4;
  parameter int PIX_W   = 12;
  parameter int NUM_SEQ = 12;
  parameter int PTR_W   = 4;
endpackage

// File: rtl/sgl_shadow.sv
module sgl_shadow #(
  parameter int NUM_V = sgl_pkg::NUM_V,
  parameter int PIX_W = sgl_pkg::PIX_W,
  parameter int PTR_W = sgl_pkg::PTR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hd,
  input  logic                   sg_line,
  input  logic                   mode_en,
  input  logic [NUM_V*PIX_W-1:0] start_in,
  input  logic [NUM_V*PTR_W-1:0] ptr_in,
  input  logic [NUM_V-1:0]       inv_in,
  output logic                   armed,
  output logic [NUM_V*PIX_W-1:0] sh_start,
  output logic [NUM_V*PTR_W-1:0] sh_ptr,
  output logic [NUM_V-1:0]       sh_inv
);
  logic                   armed_d;
  logic [NUM_V*PIX_W-1:0] start_d;
  logic [NUM_V*PTR_W-1:0] ptr_d;
  logic [NUM_V-1:0]       inv_d;
  logic                   cap_en;

  assign cap_en = hd;

  always_comb begin
    armed_d = armed;
    start_d = sh_start;
    ptr_d   = sh_ptr;
    inv_d   = sh_inv;
    if (cap_en) begin
      armed_d = sg_line & mode_en;
      start_d = start_in;
      ptr_d   = ptr_in;
      inv_d   = inv_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      sh_start <= '0;
      sh_ptr   <= '0;
      sh_inv   <= '0;
    end else begin
      armed    <= armed_d;
      sh_start <= start_d;
      sh_ptr   <= ptr_d;
      sh_inv   <= inv_d;
    end
  end

  // R7: captured settings move only on a strobe
  p_cfg_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hd |=> ($stable(sh_start) && $stable(sh_ptr) && $stable(sh_inv) && $stable(armed)));
endmodule

// File: rtl/sgl_chan.sv
module sgl_chan #(
  parameter int PIX_W   = sgl_pkg::PIX_W,
  parameter int PTR_W   = sgl_pkg::PTR_W,
  parameter int NUM_SEQ = sgl_pkg::NUM_SEQ
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hd,
  input  logic               armed,
  input  logic [PIX_W-1:0]   start,
  input  logic [PTR_W-1:0]   ptr,
  input  logic               inv,
  input  logic [PIX_W-1:0]   pix,
  input  logic [NUM_SEQ-1:0] pool,
  input  logic               norm,
  output logic               v
);
  localparam logic [PTR_W:0] SEQ_LIM = NUM_SEQ[PTR_W:0];

  logic act, act_d, v_d;
  logic legal, pool_bit, seq_lvl, hit;

  always_comb begin
    pool_bit = 1'b0;
    for (int j = 0; j < NUM_SEQ; j++) begin
      if (ptr == j[PTR_W-1:0]) pool_bit = pool[j];
    end
    legal   = ({1'b0, ptr} < SEQ_LIM);
    seq_lvl = legal ? (pool_bit ^ inv) : 1'b0;
    hit     = !hd && armed && (act || (pix == start));
    act_d   = hd ? 1'b0 : (act | hit);
    v_d     = hit ? seq_lvl : norm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0;
      v   <= 1'b0;
    end else begin
      act <= act_d;
      v   <= v_d;
    end
  end

  // R9: strobe hands the output back to the normal sequence
  p_hd_normal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hd |=> (v == $past(norm)));
  // R2: an unarmed line passes the normal sequence
  p_unarmed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !hd) |=> (v == $past(norm)));
  // R6: illegal pointer drives zero once started
  p_illegal_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && act && !hd && !({1'b0, ptr} < SEQ_LIM)) |=> !v);
  // R4: a started second sequence stays started until the strobe
  p_latched_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !hd) |=> act);
endmodule

// File: rtl/sgl_vseq.sv
module sgl_vseq #(
  parameter int NUM_V   = sgl_pkg::NUM_V,
  parameter int PIX_W   = sgl_pkg::PIX_W,
  parameter int NUM_SEQ = sgl_pkg::NUM_SEQ,
  parameter int PTR_W   = sgl_pkg::PTR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hd,
  input  logic [PIX_W-1:0]       pix_cnt,
  input  logic                   sg_line,
  input  logic [NUM_V-1:0]       norm_v,
  input  logic [NUM_SEQ-1:0]     seq_pool,
  input  logic                   mode_en,
  input  logic [NUM_V*PIX_W-1:0] start_pos,
  input  logic [NUM_V*PTR_W-1:0] seq_ptr,
  input  logic [NUM_V-1:0]       seq_inv,
  output logic [NUM_V-1:0]       v_out
);
  logic [1:0]             rst_sync;
  logic                   rst_i_n;
  logic                   armed;
  logic [NUM_V*PIX_W-1:0] sh_start;
  logic [NUM_V*PTR_W-1:0] sh_ptr;
  logic [NUM_V-1:0]       sh_inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  sgl_shadow #(.NUM_V(NUM_V), .PIX_W(PIX_W), .PTR_W(PTR_W)) u_shadow (
    .clk(clk), .rst_n(rst_i_n), .hd(hd), .sg_line(sg_line), .mode_en(mode_en),
    .start_in(start_pos), .ptr_in(seq_ptr), .inv_in(seq_inv),
    .armed(armed), .sh_start(sh_start), .sh_ptr(sh_ptr), .sh_inv(sh_inv)
  );

  for (genvar i = 0; i < NUM_V; i++) begin : g_chan
    sgl_chan #(.PIX_W(PIX_W), .PTR_W(PTR_W), .NUM_SEQ(NUM_SEQ)) u_chan (
      .clk(clk), .rst_n(rst_i_n), .hd(hd), .armed(armed),
      .start(sh_start[i*PIX_W +: PIX_W]), .ptr(sh_ptr[i*PTR_W +: PTR_W]),
      .inv(sh_inv[i]), .pix(pix_cnt), .pool(seq_pool), .norm(norm_v[i]),
      .v(v_out[i])
    );
  end

  // R1: outputs idle while internal reset is held
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_i_n |=> (v_out == '0 || !rst_i_n || $past(rst_i_n)));
endmodule

// File: tb/sgl_vseq_test.sv
module sgl_vseq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hd;
  logic [11:0] pix_cnt;
  logic        sg_line;
  logic [3:0]  norm_v;
  logic [11:0] seq_pool;
  logic        mode_en;
  logic [11:0] bst [4];
  logic [3:0]  bptr [4];
  logic [3:0]  seq_inv;
  logic [47:0] start_pos;
  logic [15:0] seq_ptr;
  logic [3:0]  v_out;

  assign start_pos = {bst[3], bst[2], bst[1], bst[0]};
  assign seq_ptr   = {bptr[3], bptr[2], bptr[1], bptr[0]};

  always #10 clk = ~clk;

  sgl_vseq uut (
    .clk(clk), .rst_n(rst_n), .hd(hd), .pix_cnt(pix_cnt), .sg_line(sg_line),
    .norm_v(norm_v), .seq_pool(seq_pool), .mode_en(mode_en),
    .start_pos(start_pos), .seq_ptr(seq_ptr), .seq_inv(seq_inv), .v_out(v_out)
  );

  int checks = 0;
  int fails  = 0;
  int lc     = 0;
  logic [3:0] q_v [$];
  string      q_tag [$];

  // reference state
  logic        m_armed = 1'b0;
  logic [11:0] m_start [4];
  logic [3:0]  m_ptr [4];
  logic [3:0]  m_inv = '0;
  logic [3:0]  m_act = '0;

  function automatic logic [11:0] pool_of(input logic [11:0] p, input int l);
    logic [11:0] a;
    a = p * 12'd37;
    return a ^ {p[5:0], p[11:6]} ^ l[11:0];
  endfunction

  task automatic step(input logic h, input logic [11:0] p, input string tag);
    logic [3:0] e;
    logic hit;
    hd       = h;
    pix_cnt  = p;
    norm_v   = p[4:1] ^ lc[3:0];
    seq_pool = pool_of(p, lc);
    if (h) begin
      e = norm_v;
      m_armed = sg_line & mode_en;
      for (int i = 0; i < 4; i++) begin
        m_start[i] = bst[i];
        m_ptr[i]   = bptr[i];
      end
      m_inv = seq_inv;
      m_act = '0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        hit = m_armed && (m_act[i] || p == m_start[i]);
        if (hit) begin
          m_act[i] = 1'b1;
          e[i] = (m_ptr[i] < 4'd12) ? (seq_pool[m_ptr[i]] ^ m_inv[i]) : 1'b0;
        end else begin
          e[i] = norm_v[i];
        end
      end
    end
    q_v.push_back(e);
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic [11:0] s0, s1, s2, s3,
                         input logic [3:0] p0, p1, p2, p3, input logic [3:0] iv);
    bst[0] = s0; bst[1] = s1; bst[2] = s2; bst[3] = s3;
    bptr[0] = p0; bptr[1] = p1; bptr[2] = p2; bptr[3] = p3;
    seq_inv = iv;
  endtask

  task automatic run_line(input logic sg, input logic me, input int len,
                          input int pre, input string tag, input bit chg);
    sg_line = sg;
    mode_en = me;
    step(1'b1, 12'(len), "R9");
    sg_line = ~sg;
    for (int p = 0; p < len; p++) begin
      if (chg && p == len / 2) begin
        set_cfg(12'd1, 12'd2, 12'd3, 12'd4, 4'd5, 4'd6, 4'd13, 4'd8, 4'b1111);
        mode_en = ~me;
      end
      step(1'b0, 12'(p), (p < pre) ? "R3" : tag);
    end
    lc++;
  endtask

  always @(posedge clk) begin
    logic [3:0] ev;
    string tg;
    #2;
    if (q_v.size() > 0) begin
      ev = q_v.pop_front();
      tg = q_tag.pop_front();
      checks++;
      if (v_out !== ev) begin
        fails++;
        $display("FAIL %s v_out=%b expected=%b", tg, v_out, ev);
      end
    end
  end

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hd = 1'b0; pix_cnt = '0; sg_line = 1'b0; norm_v = 4'hF;
    seq_pool = '1; mode_en = 1'b1;
    set_cfg(12'd0, 12'd0, 12'd0, 12'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'b0000);
    for (int i = 0; i < 4; i++) begin m_start[i] = '0; m_ptr[i] = '0; end
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (v_out !== 4'b0000) begin
        fails++;
        $display("FAIL R1 v_out=%b expected=0000", v_out);
      end
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R2: flag low
    set_cfg(12'd5, 12'd6, 12'd7, 12'd8, 4'd1, 4'd2, 4'd3, 4'd4, 4'b0101);
    run_line(1'b0, 1'b1, 30, 0, "R2", 1'b0);
    // R2: mode low
    run_line(1'b1, 1'b0, 30, 0, "R2", 1'b0);
    // R4: mid-line switch, unreachable start on output 3
    set_cfg(12'd5, 12'd10, 12'd15, 12'd4095, 4'd0, 4'd3, 4'd7, 4'd11, 4'b0000);
    run_line(1'b1, 1'b1, 40, 5, "R4", 1'b0);
    // R5: inversion
    set_cfg(12'd8, 12'd8, 12'd8, 12'd8, 4'd2, 4'd2, 4'd2, 4'd2, 4'b0101);
    run_line(1'b1, 1'b1, 40, 8, "R5", 1'b0);
    // R6: illegal pointers
    set_cfg(12'd4, 12'd4, 12'd4, 12'd4, 4'd12, 4'd15, 4'd13, 4'd1, 4'b1111);
    run_line(1'b1, 1'b1, 40, 4, "R6", 1'b0);
    // R8: independent outputs
    set_cfg(12'd3, 12'd17, 12'd30, 12'd39, 4'd9, 4'd4, 4'd6, 4'd10, 4'b0010);
    run_line(1'b1, 1'b1, 45, 3, "R8", 1'b0);
    // R7: settings rewritten mid-line
    set_cfg(12'd25, 12'd28, 12'd31, 12'd34, 4'd0, 4'd1, 4'd2, 4'd3, 4'b1000);
    run_line(1'b1, 1'b1, 40, 25, "R7", 1'b1);
    // R9: return to normal after an active line
    run_line(1'b0, 1'b1, 20, 0, "R2", 1'b0);
    step(1'b0, 12'd0, "R2");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule